// File: doc/BRIEF.md
# Two-Wide Register Rename Table

This block keeps the speculative mapping from architectural registers to physical register tags for a front end that renames two instructions in the same cycle. Each slot names two source registers and one destination register. For each source the block returns the physical tag that currently holds its value. For each destination it installs a fresh physical tag, which a free-list queue outside the block supplies. The block raises a per-slot take strobe so that the queue can pop the tag it offered.

The older slot's destination may feed one of the younger slot's sources. When it does, the younger source gets the older slot's new tag in the same cycle and not the value still stored in the table. A second, committed copy of the map follows retirement: up to two retiring instructions write their final mappings into it each cycle. When a mispredict is signalled, the committed copy replaces the whole speculative map in one cycle and renaming is held off for that cycle.

Top module: `rename_table_2w`

## Requirements
- R1: After reset, both the speculative and the committed map send architectural register i to physical tag i, so a lookup of register i returns tag i.
- R2: A slot whose valid is high, when flush is low, returns for each source the speculative map entry of that source register, read combinationally in the same cycle.
- R3: When both slots are valid and flush is low, a younger-slot source equal to the older slot's destination returns the older slot's new tag (ren0_ptag) in that cycle instead of the table entry.
- R4: A valid slot with flush low writes its new tag into the speculative entry of its destination, and lookups see it from the next cycle on.
- R5: When both slots are valid and name the same destination, the speculative entry holds the younger slot's (ren1) tag afterwards.
- R6: A slot whose valid is low drives 0 on both source tag outputs and on its take strobe, writes nothing, and gives no forwarding to the younger slot.
- R7: A commit updates only the committed map. The speculative map, seen through later lookups, does not change until a flush.
- R8: When both commit ports are valid and name the same register, the committed entry holds the cmt1 tag.
- R9: With flush high, the speculative map equals the committed map from the next cycle on, including any commits presented in the flush cycle.
- R10: During a flush cycle no rename writes the speculative map, and both take strobes and all four source tag outputs are 0.
- R11: Each take strobe (ren0_take, ren1_take) equals its slot's valid while flush is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Mispredict: restore speculative map from committed map |
| ren0_valid | input | 1 | Older rename slot carries an instruction |
| ren0_srca | input | 3 | Older slot first source register |
| ren0_srcb | input | 3 | Older slot second source register |
| ren0_dst | input | 3 | Older slot destination register |
| ren0_ptag | input | 4 | New tag offered by the free list to the older slot |
| ren1_valid | input | 1 | Younger rename slot carries an instruction |
| ren1_srca | input | 3 | Younger slot first source register |
| ren1_srcb | input | 3 | Younger slot second source register |
| ren1_dst | input | 3 | Younger slot destination register |
| ren1_ptag | input | 4 | New tag offered by the free list to the younger slot |
| cmt0_valid | input | 1 | Older retiring instruction present |
| cmt0_areg | input | 3 | Older retiring destination register |
| cmt0_ptag | input | 4 | Older retiring physical tag |
| cmt1_valid | input | 1 | Younger retiring instruction present |
| cmt1_areg | input | 3 | Younger retiring destination register |
| cmt1_ptag | input | 4 | Younger retiring physical tag |
| ren0_tag_a | output | 4 | Older slot first source tag |
| ren0_tag_b | output | 4 | Older slot second source tag |
| ren1_tag_a | output | 4 | Younger slot first source tag |
| ren1_tag_b | output | 4 | Younger slot second source tag |
| ren0_take | output | 1 | Older slot pops its tag from the free list |
| ren1_take | output | 1 | Younger slot pops its tag from the free list |

## Verification
The assertions assume that every input has a defined value from the first clock edge after reset on, and that the reset is held for at least one edge so the two maps start from the identity. The new tags offered to the two slots should differ, as a real free list guarantees, but the block does not rely on this. The stimulus drives every input on the falling edge from time zero, draws the two offered tags as distinct values, and mixes directed pairs that hit forwarding, destination collisions, commit collisions and flushes with long random runs in which each of these conditions comes up often.

// File: rtl/rat2w_pkg.sv
package rat2w_pkg;

  localparam int unsigned AREGS_DEF = 8;
  localparam int unsigned PREGS_DEF = 16;
  localparam int unsigned RD_PORTS  = 4;

  // index width of a table with n entries, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rat2w_bypass.sv
module rat2w_bypass #(
  parameter int unsigned AW = 3,
  parameter int unsigned PW = 4
) (
  input  logic          older_go,
  input  logic [AW-1:0] older_dst,
  input  logic [PW-1:0] older_tag,
  input  logic          young_go,
  input  logic [AW-1:0] src,
  input  logic [PW-1:0] tbl_tag,
  output logic          hit,
  output logic [PW-1:0] tag
);

  function automatic logic dep_hit(input logic go_o, input logic go_y,
                                   input logic [AW-1:0] d, input logic [AW-1:0] s);
    return go_o && go_y && (d == s);
  endfunction

  function automatic logic [PW-1:0] pick(input logic go_y, input logic h,
                                         input logic [PW-1:0] fwd,
                                         input logic [PW-1:0] tbl);
    if (!go_y) return '0;
    return h ? fwd : tbl;
  endfunction

  always_comb begin
    hit = dep_hit(older_go, young_go, older_dst, src);
    tag = pick(young_go, hit, older_tag, tbl_tag);
  end

endmodule

// File: rtl/rat2w_spec_map.sv
module rat2w_spec_map #(
  parameter int unsigned NA  = 8,
  parameter int unsigned AW  = 3,
  parameter int unsigned PW  = 4,
  parameter int unsigned NRD = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][PW-1:0]   rd_data,
  input  logic                     we0,
  input  logic [AW-1:0]            wa0,
  input  logic [PW-1:0]            wd0,
  input  logic                     we1,
  input  logic [AW-1:0]            wa1,
  input  logic [PW-1:0]            wd1,
  input  logic                     restore,
  input  logic [NA-1:0][PW-1:0]    restore_img
);

  logic [NA-1:0][PW-1:0] map_q;
  logic [NA-1:0][PW-1:0] map_d;
  logic                  wr_collide;

  assign wr_collide = we0 && we1 && (wa0 == wa1);

  // younger write port is applied last, so it wins on a shared entry
  function automatic logic [PW-1:0] entry_next(
      input logic [PW-1:0] cur, input logic [PW-1:0] img, input logic rs,
      input logic h0, input logic [PW-1:0] d0, input logic h1, input logic [PW-1:0] d1);
    logic [PW-1:0] v;
    v = cur;
    if (h0) v = d0;
    if (h1) v = d1;
    if (rs) v = img;
    return v;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NA; gi++) begin : g_ent
      always_comb
        map_d[gi] = entry_next(map_q[gi], restore_img[gi], restore,
                               we0 && (wa0 == AW'(gi)), wd0,
                               we1 && (wa1 == AW'(gi)), wd1);
      always_ff @(posedge clk) begin
        if (!rst_n) map_q[gi] <= PW'(gi);
        else        map_q[gi] <= map_d[gi];
      end
    end
    for (gi = 0; gi < NRD; gi++) begin : g_rd
      assign rd_data[gi] = map_q[rd_addr[gi]];
    end
  endgenerate

  p_wr0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && !restore && !wr_collide) |=> map_q[$past(wa0)] == $past(wd0));

  p_wr1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we1 && !restore) |=> map_q[$past(wa1)] == $past(wd1));

  p_same_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_collide && !restore) |=> map_q[$past(wa0)] == $past(wd1));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> map_q == $past(restore_img));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we0 && !we1 && !restore) |=> $stable(map_q));

endmodule

// File: rtl/rat2w_ret_map.sv
module rat2w_ret_map #(
  parameter int unsigned NA = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned PW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  c0,
  input  logic [AW-1:0]         a0,
  input  logic [PW-1:0]         d0,
  input  logic                  c1,
  input  logic [AW-1:0]         a1,
  input  logic [PW-1:0]         d1,
  output logic [NA-1:0][PW-1:0] img_next
);

  logic [NA-1:0][PW-1:0] ret_q;
  logic                  cmt_collide;

  assign cmt_collide = c0 && c1 && (a0 == a1);

  function automatic logic [PW-1:0] retire_next(
      input logic [PW-1:0] cur, input logic h0, input logic [PW-1:0] t0,
      input logic h1, input logic [PW-1:0] t1);
    if (h1) return t1;
    if (h0) return t0;
    return cur;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NA; gi++) begin : g_ent
      always_comb
        img_next[gi] = retire_next(ret_q[gi], c0 && (a0 == AW'(gi)), d0,
                                   c1 && (a1 == AW'(gi)), d1);
      always_ff @(posedge clk) begin
        if (!rst_n) ret_q[gi] <= PW'(gi);
        else        ret_q[gi] <= img_next[gi];
      end
    end
  endgenerate

  p_cmt_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_collide |=> ret_q[$past(a0)] == $past(d1));

  p_cmt0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c0 && !cmt_collide) |=> ret_q[$past(a0)] == $past(d0));

  p_ret_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!c0 && !c1) |=> $stable(ret_q));

endmodule

// File: rtl/rename_table_2w.sv
module rename_table_2w #(
  parameter int unsigned NUM_AREGS = rat2w_pkg::AREGS_DEF,
  parameter int unsigned NUM_PREGS = rat2w_pkg::PREGS_DEF,
  parameter int unsigned AW = rat2w_pkg::idx_w(NUM_AREGS),
  parameter int unsigned PW = rat2w_pkg::idx_w(NUM_PREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren0_valid,
  input  logic [AW-1:0] ren0_srca,
  input  logic [AW-1:0] ren0_srcb,
  input  logic [AW-1:0] ren0_dst,
  input  logic [PW-1:0] ren0_ptag,
  input  logic          ren1_valid,
  input  logic [AW-1:0] ren1_srca,
  input  logic [AW-1:0] ren1_srcb,
  input  logic [AW-1:0] ren1_dst,
  input  logic [PW-1:0] ren1_ptag,
  input  logic          cmt0_valid,
  input  logic [AW-1:0] cmt0_areg,
  input  logic [PW-1:0] cmt0_ptag,
  input  logic          cmt1_valid,
  input  logic [AW-1:0] cmt1_areg,
  input  logic [PW-1:0] cmt1_ptag,
  output logic [PW-1:0] ren0_tag_a,
  output logic [PW-1:0] ren0_tag_b,
  output logic [PW-1:0] ren1_tag_a,
  output logic [PW-1:0] ren1_tag_b,
  output logic          ren0_take,
  output logic          ren1_take
);

  localparam int unsigned NRD = rat2w_pkg::RD_PORTS;

  logic                       go0, go1;
  logic [NRD-1:0][AW-1:0]     rd_addr;
  logic [NRD-1:0][PW-1:0]     rd_tag;
  logic [NUM_AREGS-1:0][PW-1:0] ret_img;
  logic [1:0]                 young_src;
  logic [1:0][AW-1:0]         young_addr;
  logic [1:0][PW-1:0]         young_tag;
  logic [1:0]                 fwd_hit;

  initial begin
    if (NUM_PREGS < NUM_AREGS)
      $error("identity reset mapping needs at least as many tags as registers");
  end

  assign go0 = ren0_valid && !flush;
  assign go1 = ren1_valid && !flush;
  assign ren0_take = go0;
  assign ren1_take = go1;

  assign rd_addr[0] = ren0_srca;
  assign rd_addr[1] = ren0_srcb;
  assign rd_addr[2] = ren1_srca;
  assign rd_addr[3] = ren1_srcb;

  rat2w_spec_map #(.NA(NUM_AREGS), .AW(AW), .PW(PW), .NRD(NRD)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_tag),
    .we0(go0), .wa0(ren0_dst), .wd0(ren0_ptag),
    .we1(go1), .wa1(ren1_dst), .wd1(ren1_ptag),
    .restore(flush), .restore_img(ret_img)
  );

  rat2w_ret_map #(.NA(NUM_AREGS), .AW(AW), .PW(PW)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .c0(cmt0_valid), .a0(cmt0_areg), .d0(cmt0_ptag),
    .c1(cmt1_valid), .a1(cmt1_areg), .d1(cmt1_ptag),
    .img_next(ret_img)
  );

  assign young_src = 2'b11;
  assign young_addr[0] = ren1_srca;
  assign young_addr[1] = ren1_srcb;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_byp
      rat2w_bypass #(.AW(AW), .PW(PW)) u_byp (
        .older_go(go0), .older_dst(ren0_dst), .older_tag(ren0_ptag),
        .young_go(go1 && young_src[gi]), .src(young_addr[gi]),
        .tbl_tag(rd_tag[2+gi]),
        .hit(fwd_hit[gi]), .tag(young_tag[gi])
      );
    end
  endgenerate

  assign ren0_tag_a = go0 ? rd_tag[0] : '0;
  assign ren0_tag_b = go0 ? rd_tag[1] : '0;
  assign ren1_tag_a = young_tag[0];
  assign ren1_tag_b = young_tag[1];

  p_fwd_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren0_valid && ren1_valid && !flush && ren1_srca == ren0_dst) |-> ren1_tag_a == ren0_ptag);

  p_fwd_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren0_valid && ren1_valid && !flush && ren1_srcb == ren0_dst) |-> ren1_tag_b == ren0_ptag);

  p_idle_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ren0_valid |-> (!ren0_take && ren0_tag_a == '0 && ren0_tag_b == '0 && fwd_hit == 2'b00));

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!ren0_take && !ren1_take && ren1_tag_a == '0 && ren1_tag_b == '0));

  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (ren0_take == ren0_valid && ren1_take == ren1_valid));

endmodule

// File: tb/tb_rename_table_2w.sv
`timescale 1ns/1ps
module tb_rename_table_2w;

  localparam int NA = 8;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic ren0_valid = 1'b0, ren1_valid = 1'b0;
  logic [2:0] ren0_srca = '0, ren0_srcb = '0, ren0_dst = '0;
  logic [2:0] ren1_srca = '0, ren1_srcb = '0, ren1_dst = '0;
  logic [3:0] ren0_ptag = '0, ren1_ptag = '0;
  logic cmt0_valid = 1'b0, cmt1_valid = 1'b0;
  logic [2:0] cmt0_areg = '0, cmt1_areg = '0;
  logic [3:0] cmt0_ptag = '0, cmt1_ptag = '0;
  logic [3:0] ren0_tag_a, ren0_tag_b, ren1_tag_a, ren1_tag_b;
  logic ren0_take, ren1_take;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int spec_m[NA];
  int ret_m[NA];

  always #4 clk = ~clk;

  rename_table_2w dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren0_valid(ren0_valid), .ren0_srca(ren0_srca), .ren0_srcb(ren0_srcb),
    .ren0_dst(ren0_dst), .ren0_ptag(ren0_ptag),
    .ren1_valid(ren1_valid), .ren1_srca(ren1_srca), .ren1_srcb(ren1_srcb),
    .ren1_dst(ren1_dst), .ren1_ptag(ren1_ptag),
    .cmt0_valid(cmt0_valid), .cmt0_areg(cmt0_areg), .cmt0_ptag(cmt0_ptag),
    .cmt1_valid(cmt1_valid), .cmt1_areg(cmt1_areg), .cmt1_ptag(cmt1_ptag),
    .ren0_tag_a(ren0_tag_a), .ren0_tag_b(ren0_tag_b),
    .ren1_tag_a(ren1_tag_a), .ren1_tag_b(ren1_tag_b),
    .ren0_take(ren0_take), .ren1_take(ren1_take)
  );

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive on the falling edge, compare before the rising edge,
  // then advance the reference model as the edge happens
  task automatic step(input bit v0, input int s0a, input int s0b, input int d0, input int p0,
                      input bit v1, input int s1a, input int s1b, input int d1, input int p1,
                      input bit c0, input int c0a, input int c0t,
                      input bit c1, input int c1a, input int c1t, input bit fl);
    int e0a, e0b, e1a, e1b;
    @(negedge clk);
    ren0_valid = v0; ren0_srca = 3'(s0a); ren0_srcb = 3'(s0b); ren0_dst = 3'(d0); ren0_ptag = 4'(p0);
    ren1_valid = v1; ren1_srca = 3'(s1a); ren1_srcb = 3'(s1b); ren1_dst = 3'(d1); ren1_ptag = 4'(p1);
    cmt0_valid = c0; cmt0_areg = 3'(c0a); cmt0_ptag = 4'(c0t);
    cmt1_valid = c1; cmt1_areg = 3'(c1a); cmt1_ptag = 4'(c1t);
    flush = fl;
    #1;
    e0a = 0; e0b = 0; e1a = 0; e1b = 0;
    if (v0 && !fl) begin e0a = spec_m[s0a]; e0b = spec_m[s0b]; end
    if (v1 && !fl) begin
      e1a = (v0 && d0 == s1a) ? p0 : spec_m[s1a];
      e1b = (v0 && d0 == s1b) ? p0 : spec_m[s1b];
    end
    check("ren0_tag_a", int'(ren0_tag_a), e0a);
    check("ren0_tag_b", int'(ren0_tag_b), e0b);
    check("ren1_tag_a", int'(ren1_tag_a), e1a);
    check("ren1_tag_b", int'(ren1_tag_b), e1b);
    check("ren0_take", int'(ren0_take), int'(v0 && !fl));
    check("ren1_take", int'(ren1_take), int'(v1 && !fl));
    @(posedge clk);
    if (c0) ret_m[c0a] = c0t;
    if (c1) ret_m[c1a] = c1t;
    if (fl) begin
      foreach (spec_m[k]) spec_m[k] = ret_m[k];
    end else begin
      if (v0) spec_m[d0] = p0;
      if (v1) spec_m[d1] = p1;
    end
  endtask

  // lookups that rewrite each destination with the value it already holds
  task automatic read_pair(input int a, input int b, input int c, input int d);
    step(1, a, b, a, spec_m[a], 1, c, d, c, spec_m[c], 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    foreach (spec_m[k]) begin spec_m[k] = k; ret_m[k] = k; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity after reset
    cur_req = "R1";
    read_pair(0, 1, 2, 3);
    read_pair(4, 5, 6, 7);

    // R2/R4: renames land in the table, visible next cycle
    cur_req = "R4";
    step(1, 1, 2, 3, 9, 1, 4, 5, 6, 12, 0, 0, 0, 0, 0, 0, 0);
    read_pair(3, 6, 1, 2);
    cur_req = "R2";
    read_pair(0, 3, 6, 7);

    // R3: younger sources forwarded from older destination
    cur_req = "R3";
    step(1, 0, 0, 2, 10, 1, 2, 2, 5, 11, 0, 0, 0, 0, 0, 0, 0);
    step(1, 7, 7, 4, 13, 1, 4, 1, 4, 14, 0, 0, 0, 0, 0, 0, 0);

    // R5: same destination in both slots, younger stays
    cur_req = "R5";
    step(1, 0, 1, 7, 8, 1, 2, 3, 7, 15, 0, 0, 0, 0, 0, 0, 0);
    read_pair(7, 7, 0, 7);

    // R6: idle slots neither read, write nor forward
    cur_req = "R6";
    step(0, 3, 3, 3, 1, 1, 3, 3, 0, 9, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 6, 2, 0, 6, 6, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    read_pair(3, 0, 6, 1);

    // R7: commits leave the speculative map alone
    cur_req = "R7";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 5, 1, 3, 6, 0);
    read_pair(2, 3, 0, 1);

    // R8 then R9: colliding commits, flush, observe restored map
    cur_req = "R8";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 7, 1, 4, 11, 0);
    cur_req = "R9";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cur_req = "R8";
    read_pair(4, 2, 3, 4);

    // R9: flush with same-cycle commit, R10: renames suppressed
    cur_req = "R10";
    step(1, 1, 2, 1, 13, 1, 1, 2, 2, 14, 1, 5, 12, 0, 0, 0, 1);
    cur_req = "R9";
    read_pair(5, 1, 2, 6);

    // R11 and everything else: random traffic against the model
    cur_req = "R11";
    idle();
    for (int i = 0; i < 4000; i++) begin
      int p0, p1;
      p0 = $urandom_range(NP - 1);
      p1 = (p0 + 1 + $urandom_range(NP - 2)) % NP;
      cur_req = (i % 2 == 0) ? "R2" : "R11";
      step($urandom_range(3) != 0, $urandom_range(NA - 1), $urandom_range(NA - 1),
           $urandom_range(NA - 1), p0,
           $urandom_range(3) != 0, $urandom_range(NA - 1), $urandom_range(NA - 1),
           $urandom_range(NA - 1), p1,
           $urandom_range(1), $urandom_range(NA - 1), $urandom_range(NP - 1),
           $urandom_range(1), $urandom_range(NA - 1), $urandom_range(NP - 1),
           $urandom_range(15) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule